// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a sixteen-line general-purpose I/O controller with a small word-addressed register file. Each line has its own direction bit. A line set as an output drives its pad from the output data register. A line set as an input is brought into the clock domain through a two-flop synchroniser. It can then latch a sticky status bit on a rising or a falling edge, chosen per line, unless the line is masked. One registered level interrupt stays high while any status bit is set. Software clears status bits by writing ones to them.

Software reaches the block through single-cycle read and write strobes, a 3-bit word address and 16-bit data. Read data comes back one cycle after the read strobe. The register map is: word 0, synchronised inputs gated by the pin-enable register (read-only); word 1, output data; word 2, direction (1 = input); word 3, edge select (1 = rising, 0 = falling); word 4, mask (1 = masked); word 5, status (write one to clear); word 6, pin enable; word 7, unmapped. Reset leaves every line as a masked, rising-edge input with the output data at all ones.

Top module: `edge_irq_gpio`

## Requirements
- R1: After reset, words 1, 2, 3, 4 and 6 read 0xFFFF, words 0 and 5 read 0x0000, padOe is 0x0000 and irqOut is 0.
- R2: padOut equals output data AND NOT direction, and padOe equals NOT direction. Both follow a write to word 1 or word 2 in the cycle after the write strobe.
- R3: An input line (direction 1) that is unmasked (mask 0), with edge select 1, sets its status bit on a 0→1 change of its synchronised value.
- R4: An input line that is unmasked, with edge select 0, sets its status bit on a 1→0 change.
- R5: A line that is masked, or that is an output (direction 0), never sets its status bit, whatever its pin does.
- R6: Writing word 5 clears every status bit written as 1 and leaves the other bits unchanged.
- R7: irqOut is a register equal to the OR of the status bits one cycle earlier.
- R8: If an edge event and a clear of the same status bit fall in the same cycle, the bit stays set.
- R9: Reading word 0 returns the synchronised inputs AND the pin-enable register. Writes to word 0 change nothing.
- R10: Reading word 7 returns 0, and a write to word 7 changes no register.
- R11: rdData shows the addressed register in the cycle after the read strobe.
- R12: A pin change is seen through two synchroniser flops. The status bit sets on the third rising clock edge after the change, and irqOut rises on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Word address of the register |
| wrEn | input | 1 | One-cycle write strobe |
| rdEn | input | 1 | One-cycle read strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data |
| pinIn | input | 16 | Raw, asynchronous pin levels |
| padOut | output | 16 | Value driven onto the pads |
| padOe | output | 16 | Pad output enable, 1 = drive |
| irqOut | output | 1 | Level interrupt |

## Verification
The case that is hardest to reach from the ports is an edge event landing in exactly the cycle in which software clears the same status bit. The event is buried behind three flops, so the bench has to count that pipeline. It toggles a pin on a falling clock edge, lets two rising edges pass, and then places the clear strobe so that it is sampled on the third rising edge, the one on which the event is latched. Random register writes, including writes to the read-only and unmapped words, are mixed with spaced pin changes. A bench model tracks the expected status and pad state throughout.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GPIO_ADDR_W = 3;

  typedef enum logic [GPIO_ADDR_W-1:0] {
    SEL_IN   = 3'd0,
    SEL_OUT  = 3'd1,
    SEL_DIR  = 3'd2,
    SEL_EDGE = 3'd3,
    SEL_MASK = 3'd4,
    SEL_STAT = 3'd5,
    SEL_PIN  = 3'd6,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrOut;
    logic    wrDir;
    logic    wrEdge;
    logic    wrMask;
    logic    wrStat;
    logic    wrPin;
    logic    rdStrobe;
    regSel_e rdSel;
  } gpioStrb_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [GPIO_ADDR_W-1:0] busAddr,
  input  logic                   wrEn,
  input  logic                   rdEn,
  output gpioStrb_t              strb
);
  regSel_e sel;
  assign sel = regSel_e'(busAddr);

  always_comb begin
    strb          = '0;
    strb.rdSel    = sel;
    strb.rdStrobe = rdEn;
    if (wrEn) begin
      case (sel)
        SEL_OUT:  strb.wrOut  = 1'b1;
        SEL_DIR:  strb.wrDir  = 1'b1;
        SEL_EDGE: strb.wrEdge = 1'b1;
        SEL_MASK: strb.wrMask = 1'b1;
        SEL_STAT: strb.wrStat = 1'b1;
        SEL_PIN:  strb.wrPin  = 1'b1;
        default:  ;
      endcase
    end
  end

  // R10 / R9: writes to the unmapped word and the read-only word raise no strobe
  p_dead_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (busAddr == 3'd7 || busAddr == 3'd0)) |->
      !(strb.wrOut | strb.wrDir | strb.wrEdge | strb.wrMask | strb.wrStat | strb.wrPin));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrOut, strb.wrDir, strb.wrEdge, strb.wrMask, strb.wrStat, strb.wrPin}));
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int LINES       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpioStrb_t        strb,
  input  logic [LINES-1:0] wrData,
  input  logic [LINES-1:0] pinIn,
  output logic [LINES-1:0] rdData,
  output logic [LINES-1:0] padOut,
  output logic [LINES-1:0] padOe,
  output logic             irqOut
);
  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [LINES-1:0] ONES = '1;

  logic [LINES-1:0] syncPipe [SYNC_STAGES];
  logic [LINES-1:0] prevIn;
  logic [LINES-1:0] outReg, dirReg, edgeReg, maskReg, statReg, pinReg;
  logic [LINES-1:0] riseEvt, fallEvt, edgeEvt;
  logic [LINES-1:0] rdMux;

  // synchroniser chain
  always_ff @(posedge clk) begin
    if (!rstN) syncPipe[0] <= '0;
    else       syncPipe[0] <= pinIn;
  end
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncPipe[s] <= '0;
      else       syncPipe[s] <= syncPipe[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncPipe[LAST];
  end

  assign riseEvt = syncPipe[LAST] & ~prevIn;
  assign fallEvt = ~syncPipe[LAST] & prevIn;
  assign edgeEvt = dirReg & ~maskReg & ((edgeReg & riseEvt) | (~edgeReg & fallEvt));

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg  <= ONES;
      dirReg  <= ONES;
      edgeReg <= ONES;
      maskReg <= ONES;
      pinReg  <= ONES;
    end else begin
      if (strb.wrOut)  outReg  <= wrData;
      if (strb.wrDir)  dirReg  <= wrData;
      if (strb.wrEdge) edgeReg <= wrData;
      if (strb.wrMask) maskReg <= wrData;
      if (strb.wrPin)  pinReg  <= wrData;
    end
  end

  // sticky status, new event wins over clear
  always_ff @(posedge clk) begin
    if (!rstN) statReg <= '0;
    else       statReg <= (statReg & ~(strb.wrStat ? wrData : '0)) | edgeEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |statReg;
  end

  assign padOut = outReg & ~dirReg;
  assign padOe  = ~dirReg;

  always_comb begin
    case (strb.rdSel)
      SEL_IN:   rdMux = syncPipe[LAST] & pinReg;
      SEL_OUT:  rdMux = outReg;
      SEL_DIR:  rdMux = dirReg;
      SEL_EDGE: rdMux = edgeReg;
      SEL_MASK: rdMux = maskReg;
      SEL_STAT: rdMux = statReg;
      SEL_PIN:  rdMux = pinReg;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (strb.rdStrobe) rdData <= rdMux;
  end

  // R5: newly set status bits only on unmasked input lines
  p_legal_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statReg & ~$past(statReg) & ~$past(dirReg & ~maskReg)) == '0));

  // R6: bits written as one are clear afterwards unless an event hit them
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStat |=> ((statReg & $past(wrData & ~edgeEvt)) == '0));

  // R7: interrupt follows the status vector by one cycle
  p_irq_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|statReg) |=> irqOut);
  p_irq_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statReg == '0) |=> !irqOut);

  // R10: output data only moves on its own strobe
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrOut |=> $stable(outReg));
endmodule

// File: rtl/edge_irq_gpio.sv
module edge_irq_gpio
  import gpio_pkg::*;
#(
  parameter int LINES       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [GPIO_ADDR_W-1:0] busAddr,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [LINES-1:0]       wrData,
  output logic [LINES-1:0]       rdData,
  input  logic [LINES-1:0]       pinIn,
  output logic [LINES-1:0]       padOut,
  output logic [LINES-1:0]       padOe,
  output logic                   irqOut
);
  gpioStrb_t strb;

  gpio_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strb    (strb)
  );

  gpio_datapath #(
    .LINES       (LINES),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .pinIn  (pinIn),
    .rdData (rdData),
    .padOut (padOut),
    .padOe  (padOe),
    .irqOut (irqOut)
  );
endmodule

// File: tb/edge_irq_gpio_tb_top.sv
`timescale 1ns/1ps
module edge_irq_gpio_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0, pinIn = '0;
  logic [15:0] rdData, padOut, padOe;
  logic        irqOut;

  int nChecks = 0, nFails = 0;
  logic [15:0] mIn, mOut, mDir, mEdge, mMask, mStat, mPin;

  always #2.5 clk = ~clk;

  edge_irq_gpio dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .padOut(padOut),
    .padOe(padOe), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mIn & mPin;
      3'd1: return mOut;
      3'd2: return mDir;
      3'd3: return mEdge;
      3'd4: return mMask;
      3'd5: return mStat;
      3'd6: return mPin;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] expEvt(input logic [15:0] oldV, input logic [15:0] newV);
    return mDir & ~mMask & ((mEdge & newV & ~oldV) | (~mEdge & ~newV & oldV));
  endfunction

  // called at a falling edge; returns at a falling edge
  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    case (a)
      3'd1: mOut = d;
      3'd2: mDir = d;
      3'd3: mEdge = d;
      3'd4: mMask = d;
      3'd5: mStat = mStat & ~d;
      3'd6: mPin = d;
      default: ;
    endcase
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] d);
    busAddr = a; rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic readCheck(input logic [2:0] a, input string req);
    logic [15:0] d;
    busRead(a, d);
    check(d === expRead(a), req, d, expRead(a));
  endtask

  task automatic setPins(input logic [15:0] v);
    mStat = mStat | expEvt(mIn, v);
    mIn = v;
    pinIn = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1234));
    mIn = 0; mOut = '1; mDir = '1; mEdge = '1; mMask = '1; mStat = 0; mPin = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) readCheck(3'(a), "R1");
    check(padOe === 16'h0, "R1 padOe", padOe, 16'h0);
    check(irqOut === 1'b0, "R1 irq", {15'h0, irqOut}, 16'h0);

    // R12/R3/R7 timing of a rising event on line 0
    busWrite(3'd4, 16'hFFFE);
    pinIn = 16'h0001; mIn = 16'h0001; mStat = 16'h0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(irqOut === 1'b0, "R12 irq not yet", {15'h0, irqOut}, 16'h0);
    @(posedge clk); @(negedge clk);
    check(irqOut === 1'b1, "R12 irq on fourth edge", {15'h0, irqOut}, 16'h1);
    readCheck(3'd5, "R3 rising status");

    // R6 clear
    busWrite(3'd5, 16'h0001);
    readCheck(3'd5, "R6 cleared");
    check(irqOut === 1'b0, "R7 irq drops", {15'h0, irqOut}, 16'h0);

    // R8 event and clear in the same cycle, falling edge on line 0
    busWrite(3'd3, 16'hFFFE);
    pinIn = 16'h0000; mIn = 16'h0000;
    @(posedge clk); @(posedge clk); @(negedge clk);
    busWrite(3'd5, 16'h0001);
    mStat = 16'h0001;
    readCheck(3'd5, "R8 event wins");
    readCheck(3'd5, "R4 falling status held");
    busWrite(3'd5, 16'h0001);
    readCheck(3'd5, "R6 cleared again");

    // R5 output line and masked line never set status
    busWrite(3'd2, 16'hFFFD);
    busWrite(3'd4, 16'hFFFC);
    check(padOut === 16'h0002, "R2 padOut", padOut, 16'h0002);
    check(padOe === 16'h0002, "R2 padOe", padOe, 16'h0002);
    busWrite(3'd4, 16'hFFFD);
    setPins(16'h0006);
    readCheck(3'd5, "R5 output and masked lines");
    busWrite(3'd1, 16'h0000);
    check(padOut === 16'h0000, "R2 padOut after data write", padOut, 16'h0);

    // R9 input readback gated, writes ignored
    readCheck(3'd0, "R9 input read");
    busWrite(3'd6, 16'hFFFB);
    readCheck(3'd0, "R9 gated read");
    busWrite(3'd0, 16'hFFFF);
    readCheck(3'd0, "R9 write ignored");

    // R10 unmapped
    busWrite(3'd7, 16'h1234);
    readCheck(3'd7, "R10 unmapped read");
    for (int a = 1; a < 7; a++) readCheck(3'(a), "R10 no side effect");

    // R11 latency: data appears the cycle after the strobe
    busAddr = 3'd6; rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    check(rdData === mPin, "R11 latency", rdData, mPin);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 2);
      if (op == 0) begin
        logic [2:0] a;
        a = 3'($urandom_range(0, 7));
        busWrite(a, 16'($urandom));
        check(padOut === (mOut & ~mDir), "R2 random padOut", padOut, mOut & ~mDir);
        check(padOe === ~mDir, "R2 random padOe", padOe, ~mDir);
      end else if (op == 1) begin
        setPins(16'($urandom));
        check(irqOut === (|mStat), "R7 random irq", {15'h0, irqOut}, {15'h0, |mStat});
        readCheck(3'd5, "R3 R4 R5 random status");
      end else begin
        busRead(3'($urandom_range(0, 7)), d);
        check(d === expRead(busAddr), "R11 random read", d, expRead(busAddr));
        check(irqOut === (|mStat), "R7 irq level", {15'h0, irqOut}, {15'h0, |mStat});
      end
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule